// File: doc/BRIEF.md
# Boot-Remappable System Address Decoder

This block sits on one bus master's address path and turns each transfer address into a single slave select, or into an error flag when the address lands in unmapped space. It decodes in two levels. The top four address bits pick one of sixteen 256 MB banks. Inside the internal-memory bank, address bits [27:20] pick a 1 MB region. Inside the top bank, bits [27:24] split the space between the peripheral bridge and two coprocessor windows.

The region at address zero is not fixed. A boot-mode pin is captured while reset is held. After reset, while the remap bit is clear, that captured value chooses between the internal ROM and external chip select 0 at address zero. Software then sets a remap bit with a one-cycle command pulse. From then on, address zero reaches SRAM. A separate pulse clears the bit again. Commands are accepted only on cycles with no transfer in flight, so the map never changes under a live access.

Top module: `boot_remap_decoder`

## Requirements
- R1: While `xfer_valid` is high, exactly one bit of {`xfer_err`, `slave_sel`} is high. The `slave_sel` bit positions are: 0 ROM, 1 SRAM, 2 coprocessor slave 0 line 0, 3 coprocessor slave 0 line 1, 4..9 external chip selects 0..5, 10 SDRAM/DDR select, 11 coprocessor external-memory slave, 12 peripheral bridge, 13 coprocessor slave 3 low window, 14 coprocessor slave 3 high window.
- R2: While `xfer_valid` is low, `slave_sel` is all zero and `xfer_err` is low, whatever the address.
- R3: Banks 1 to 6 (address bits [31:28]) select external chip selects 0 to 5 in order, and bank 7 selects the SDRAM/DDR select (bit 10).
- R4: Banks 8, 9, 10 and 11 all select the coprocessor external-memory slave (bit 11).
- R5: In bank 15, addresses 0xFF00_0000 and above select the peripheral bridge (bit 12). Addresses 0xF000_0000–0xF7FF_FFFF select bit 13, and 0xF800_0000–0xFEFF_FFFF select bit 14.
- R6: In bank 0, the 1 MB regions 1, 2, 3 and 4 select SRAM, coprocessor slave 0 line 0, coprocessor slave 0 line 1 and ROM. These regions do not depend on the remap or boot state.
- R7: Bank 0 region 0 selects SRAM when remap is 1. When remap is 0, it selects ROM if the captured boot mode is 1 and external chip select 0 if it is 0.
- R8: The boot mode is the value of `boot_pin` on the last clock edge with `rst_n` low. Changes on `boot_pin` after reset have no effect.
- R9: Remap is 0 after reset. An edge with `remap_set` high sets it, and an edge with `remap_clr` high clears it. When both are high, clear wins.
- R10: Remap commands on an edge where `xfer_valid` is high are ignored.
- R11: Banks 12, 13 and 14, and bank-0 regions 5 to 255, raise `xfer_err` with no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_pin | input | 1 | Boot-mode select, captured during reset |
| remap_set | input | 1 | One-cycle pulse that sets remap |
| remap_clr | input | 1 | One-cycle pulse that clears remap |
| xfer_valid | input | 1 | Transfer strobe |
| xfer_addr | input | 32 | Transfer byte address |
| slave_sel | output | 15 | One-hot slave selects, bit order as in R1 |
| xfer_err | output | 1 | Abort response for unmapped addresses |

## Verification
The block holds only two bits of state: the captured boot mode and the remap bit. If either is wrong, the only place it shows is the select for region zero of bank 0. The error becomes visible on the first access there after the fault, in the same cycle, and no other address reveals it. For this reason the bench goes back to address zero after every remap command, after any change on the boot pin, and after each command given during a live transfer. Random traffic is mixed in against a model that follows the rules for when commands are accepted. Every other bank decodes purely from the address, so a decode error there appears combinationally on the faulty address.

// File: rtl/bdec_pkg.sv
// Package: shared widths, bank numbers and select bit positions for the
// boot-remappable address decoder. Assumes a 32-bit byte address.
package bdec_pkg;
    localparam int ADDR_W      = 32;
    localparam int BANK_W      = 4;
    localparam int BANK_LSB    = ADDR_W - BANK_W;         // 28
    localparam int REGION_W    = 8;
    localparam int REGION_LSB  = BANK_LSB - REGION_W;     // 20
    localparam int SUB_W       = 4;
    localparam int SUB_LSB     = BANK_LSB - SUB_W;        // 24

    localparam int NUM_EXT_CS  = 7;                       // cs0..cs5 + sdram
    localparam int EXT_FIRST_BANK = 1;
    localparam int CPX_FIRST_BANK = 8;
    localparam int CPX_LAST_BANK  = 11;
    localparam int HI_BANK        = 15;

    // Select bit positions (R1)
    localparam int SEL_ROM     = 0;
    localparam int SEL_SRAM    = 1;
    localparam int SEL_CP0_A   = 2;
    localparam int SEL_CP0_B   = 3;
    localparam int SEL_ECS0    = 4;
    localparam int SEL_SDRAM   = SEL_ECS0 + NUM_EXT_CS - 1; // 10
    localparam int SEL_CPX     = SEL_SDRAM + 1;            // 11
    localparam int SEL_BRIDGE  = 12;
    localparam int SEL_CP3_LO  = 13;
    localparam int SEL_CP3_HI  = 14;
    localparam int NUM_SEL     = 15;

    typedef logic [NUM_SEL-1:0] sel_vec_t;
endpackage

// File: rtl/bdec_mode_reg.sv
// Mode register: holds the boot mode captured during reset and the remap
// bit. Assumes remap commands are single-cycle pulses; they are accepted
// only on edges with no transfer strobe.
module bdec_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic boot_pin,
    input  logic xfer_valid,
    input  logic remap_set,
    input  logic remap_clr,
    output logic boot_rom,
    output logic remap
);
    logic boot_q;
    logic remap_q;

    // Capture boot mode under reset; update remap between transfers only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q  <= boot_pin;
            remap_q <= 1'b0;
        end else if (!xfer_valid) begin
            if (remap_clr)
                remap_q <= 1'b0;
            else if (remap_set)
                remap_q <= 1'b1;
        end
    end

    assign boot_rom = boot_q;
    assign remap    = remap_q;

    AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(boot_q)); // R8
    AST_REMAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> $stable(remap_q)); // R10
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (remap_clr && !xfer_valid) |=> !remap_q); // R9
endmodule

// File: rtl/bdec_bank0.sv
// Bank-0 second-level decoder: maps 1 MB regions to internal memories.
// Region 0 depends on remap and boot mode; regions above 4 are unmapped.
// Purely combinational, not qualified by the transfer strobe.
module bdec_bank0
    import bdec_pkg::*;
(
    input  logic [REGION_W-1:0] region,
    input  logic                boot_rom,
    input  logic                remap,
    output sel_vec_t            sel,
    output logic                err
);
    // Decode the region number into one select or an error.
    always_comb begin
        sel = '0;
        err = 1'b0;
        case (region)
            8'd0: begin
                if (remap)
                    sel[SEL_SRAM] = 1'b1;
                else if (boot_rom)
                    sel[SEL_ROM] = 1'b1;
                else
                    sel[SEL_ECS0] = 1'b1;
            end
            8'd1:    sel[SEL_SRAM]  = 1'b1;
            8'd2:    sel[SEL_CP0_A] = 1'b1;
            8'd3:    sel[SEL_CP0_B] = 1'b1;
            8'd4:    sel[SEL_ROM]   = 1'b1;
            default: err = 1'b1;
        endcase
    end
endmodule

// File: rtl/bdec_ext.sv
// External-bank decoder: one chip select per bank from EXT_FIRST_BANK on,
// the last of them being the SDRAM/DDR select. Combinational.
module bdec_ext
    import bdec_pkg::*;
(
    input  logic [BANK_W-1:0]     bank,
    output logic [NUM_EXT_CS-1:0] cs
);
    for (genvar i = 0; i < NUM_EXT_CS; i++) begin : g_cs
        assign cs[i] = (bank == BANK_W'(EXT_FIRST_BANK + i));
    end
endmodule

// File: rtl/bdec_bank15.sv
// Top-bank decoder: top 16 MB go to the peripheral bridge, the rest split
// into two coprocessor windows by bit 27. Every address here is mapped.
module bdec_bank15
    import bdec_pkg::*;
(
    input  logic [SUB_W-1:0] sub,
    output sel_vec_t         sel
);
    // Pick bridge, low window or high window.
    always_comb begin
        sel = '0;
        if (sub == {SUB_W{1'b1}})
            sel[SEL_BRIDGE] = 1'b1;
        else if (!sub[SUB_W-1])
            sel[SEL_CP3_LO] = 1'b1;
        else
            sel[SEL_CP3_HI] = 1'b1;
    end
endmodule

// File: rtl/boot_remap_decoder.sv
// Top: first-level bank decode of a master's address into one-hot slave
// selects or an abort flag, with boot/remap-dependent decode at zero.
// Assumes the address is stable while xfer_valid is high.
module boot_remap_decoder
    import bdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_pin,
    input  logic              remap_set,
    input  logic              remap_clr,
    input  logic              xfer_valid,
    input  logic [ADDR_W-1:0] xfer_addr,
    output logic [NUM_SEL-1:0] slave_sel,
    output logic              xfer_err
);
    logic [BANK_W-1:0]     bank;
    logic                  boot_rom;
    logic                  remap;
    sel_vec_t              b0_sel;
    logic                  b0_err;
    sel_vec_t              b15_sel;
    logic [NUM_EXT_CS-1:0] ext_cs;
    sel_vec_t              raw_sel;
    logic                  raw_err;
    logic                  unused_low;

    assign bank       = xfer_addr[ADDR_W-1:BANK_LSB];
    assign unused_low = ^xfer_addr[REGION_LSB-1:0];

    bdec_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_pin   (boot_pin),
        .xfer_valid (xfer_valid),
        .remap_set  (remap_set),
        .remap_clr  (remap_clr),
        .boot_rom   (boot_rom),
        .remap      (remap)
    );

    bdec_bank0 u_bank0 (
        .region   (xfer_addr[BANK_LSB-1:REGION_LSB]),
        .boot_rom (boot_rom),
        .remap    (remap),
        .sel      (b0_sel),
        .err      (b0_err)
    );

    bdec_ext u_ext (
        .bank (bank),
        .cs   (ext_cs)
    );

    bdec_bank15 u_bank15 (
        .sub (xfer_addr[BANK_LSB-1:SUB_LSB]),
        .sel (b15_sel)
    );

    // First-level bank decode: route to the sub-decoder for this bank.
    always_comb begin
        raw_sel = '0;
        raw_err = 1'b0;
        if (bank == '0) begin
            raw_sel = b0_sel;
            raw_err = b0_err;
        end else if (bank < BANK_W'(EXT_FIRST_BANK + NUM_EXT_CS)) begin
            raw_sel[SEL_ECS0 +: NUM_EXT_CS] = ext_cs;
        end else if (bank >= BANK_W'(CPX_FIRST_BANK) &&
                     bank <= BANK_W'(CPX_LAST_BANK)) begin
            raw_sel[SEL_CPX] = 1'b1;
        end else if (bank == BANK_W'(HI_BANK)) begin
            raw_sel = b15_sel;
        end else begin
            raw_err = 1'b1;
        end
    end

    // Qualify every output with the transfer strobe.
    always_comb begin
        slave_sel = xfer_valid ? raw_sel : '0;
        xfer_err  = xfer_valid & raw_err;
    end

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> $countones({xfer_err, slave_sel}) == 1); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_valid |-> (slave_sel == '0 && !xfer_err)); // R2
    AST_ROM_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_addr[ADDR_W-1:REGION_LSB] == 12'h004)
        |-> slave_sel[SEL_ROM]); // R6
    AST_HOLE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && bank >= 4'd12 && bank <= 4'd14) |-> xfer_err); // R11
    AST_BRIDGE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_addr[ADDR_W-1:SUB_LSB] == 8'hFF)
        |-> slave_sel[SEL_BRIDGE]); // R5
endmodule

// File: tb/sim_boot_remap_decoder.sv
module sim_boot_remap_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_pin = 1'b1;
    logic        remap_set = 1'b0;
    logic        remap_clr = 1'b0;
    logic        xfer_valid = 1'b0;
    logic [31:0] xfer_addr = '0;
    logic [14:0] slave_sel;
    logic        xfer_err;

    int checks = 0;
    int failures = 0;
    bit m_boot;
    bit m_remap;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_remap_decoder u0 (
        .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin),
        .remap_set(remap_set), .remap_clr(remap_clr),
        .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
        .slave_sel(slave_sel), .xfer_err(xfer_err)
    );

    // Expected {err, sel} from the requirements.
    function automatic logic [15:0] expect_out(logic [31:0] a, bit v, bit b, bit r);
        logic [15:0] e;
        logic [3:0]  bk;
        logic [7:0]  rg;
        e  = '0;
        bk = a[31:28];
        rg = a[27:20];
        if (!v) return e;
        if (bk == 0) begin
            case (rg)
                8'd0: e[r ? 1 : (b ? 0 : 4)] = 1'b1;
                8'd1: e[1] = 1'b1;
                8'd2: e[2] = 1'b1;
                8'd3: e[3] = 1'b1;
                8'd4: e[0] = 1'b1;
                default: e[15] = 1'b1;
            endcase
        end else if (bk <= 7) e[3 + bk] = 1'b1;
        else if (bk <= 11) e[11] = 1'b1;
        else if (bk == 15) begin
            if (a[27:24] == 4'hF) e[12] = 1'b1;
            else if (!a[27]) e[13] = 1'b1;
            else e[14] = 1'b1;
        end else e[15] = 1'b1;
        return e;
    endfunction

    function automatic string tag_for(logic [31:0] a, bit v);
        logic [3:0] bk;
        bk = a[31:28];
        if (!v) return "R2";
        if (bk == 0) return (a[27:20] == 0) ? "R7" : (a[27:20] <= 4) ? "R6" : "R11";
        if (bk <= 7) return "R3";
        if (bk <= 11) return "R4";
        if (bk == 15) return "R5";
        return "R11";
    endfunction

    task automatic check_now(string tag);
        logic [15:0] exp_v;
        exp_v = expect_out(xfer_addr, xfer_valid, m_boot, m_remap);
        checks++;
        if ({xfer_err, slave_sel} !== exp_v) begin
            failures++;
            $display("FAIL %s addr=%h valid=%0b actual=%h expected=%h",
                     tag, xfer_addr, xfer_valid, {xfer_err, slave_sel}, exp_v);
        end
        if (xfer_valid && $countones({xfer_err, slave_sel}) != 1) begin
            failures++;
            $display("FAIL R1 addr=%h actual=%h expected one-hot", xfer_addr,
                     {xfer_err, slave_sel});
        end
    endtask

    // Drive one cycle of inputs, check, then advance the model across the edge.
    task automatic step(logic [31:0] a, bit v, bit s, bit c, string tag);
        @(negedge clk);
        xfer_addr = a; xfer_valid = v; remap_set = s; remap_clr = c;
        #1;
        check_now(tag);
        if (!v) begin
            if (c) m_remap = 1'b0;
            else if (s) m_remap = 1'b1;
        end
    endtask

    task automatic do_reset(bit b);
        @(negedge clk);
        rst_n = 1'b0; boot_pin = b;
        xfer_valid = 1'b0; remap_set = 1'b0; remap_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_boot = b; m_remap = 1'b0;
    endtask

    function automatic logic [31:0] rand_addr();
        logic [31:0] a;
        a = $urandom;
        case ($urandom % 4)
            0: a[31:28] = 4'h0;
            1: a[31:28] = 4'hF;
            default: ;
        endcase
        if (a[31:28] == 0 && ($urandom % 2)) a[27:20] = 8'($urandom % 6);
        return a;
    endfunction

    bit done = 1'b0;

    initial begin
        void'($urandom(32'd20240611));
        m_boot = 1'b1; m_remap = 1'b0;
        do_reset(1'b1);
        // Reset state: remap 0, boot high -> ROM at zero
        step(32'h0000_0000, 1, 0, 0, "R9");
        step(32'h0000_1234, 1, 0, 0, "R7");
        // R8: boot pin change after reset ignored
        boot_pin = 1'b0;
        step(32'h0000_0000, 1, 0, 0, "R8");
        // R2: idle outputs quiet
        step(32'h0000_0000, 0, 0, 0, "R2");
        step(32'hC000_0000, 0, 0, 0, "R2");
        // R3 banks 1..7, R4 banks 8..11
        for (int bk = 1; bk <= 7; bk++) step({4'(bk), 28'h0ABCDEF}, 1, 0, 0, "R3");
        for (int bk = 8; bk <= 11; bk++) step({4'(bk), 28'h1234567}, 1, 0, 0, "R4");
        // R11 holes
        for (int bk = 12; bk <= 14; bk++) step({4'(bk), 28'h0}, 1, 0, 0, "R11");
        step(32'h0050_0000, 1, 0, 0, "R11");
        step(32'h0FF0_0000, 1, 0, 0, "R11");
        // R6 fixed regions and R5 edges
        step(32'h0010_0000, 1, 0, 0, "R6");
        step(32'h0020_0000, 1, 0, 0, "R6");
        step(32'h003F_FFFF, 1, 0, 0, "R6");
        step(32'h0040_0000, 1, 0, 0, "R6");
        step(32'hF7FF_FFFF, 1, 0, 0, "R5");
        step(32'hF800_0000, 1, 0, 0, "R5");
        step(32'hFEFF_FFFF, 1, 0, 0, "R5");
        step(32'hFF00_0000, 1, 0, 0, "R5");
        // R10: set during a live transfer is ignored
        step(32'h0000_0000, 1, 1, 0, "R10");
        step(32'h0000_0000, 1, 0, 0, "R10");
        // R9: set between transfers, address zero becomes SRAM
        step(32'h0000_0000, 0, 1, 0, "R9");
        step(32'h0000_0000, 1, 0, 0, "R7");
        step(32'h0040_0000, 1, 0, 0, "R6");
        // R10: clear during transfer ignored
        step(32'h0000_0000, 1, 0, 1, "R10");
        step(32'h0000_0000, 1, 0, 0, "R10");
        // R9: clear wins over set
        step(32'h0000_0000, 0, 1, 1, "R9");
        step(32'h0000_0000, 1, 0, 0, "R9");
        // Random traffic with commands
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            bit v, s, c;
            a = rand_addr();
            v = ($urandom % 4) != 0;
            s = ($urandom % 8) == 0;
            c = ($urandom % 10) == 0;
            step(a, v, s, c, tag_for(a, v));
            step(32'h0000_0000, 1, 0, 0, "R7");
        end
        // R8/R7: boot low selects external chip select 0 at zero
        do_reset(1'b0);
        step(32'h0000_0000, 1, 0, 0, "R8");
        boot_pin = 1'b1;
        step(32'h0000_0000, 1, 0, 0, "R8");
        step(32'h0000_0000, 0, 1, 0, "R9");
        step(32'h0000_0000, 1, 0, 0, "R7");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule